// File: doc/BRIEF.md
# Dual Timer-Counter Peripheral

The block is a memory-mapped peripheral holding two independent timer channels of `DATA_W` bits. Each channel owns three word registers: a control/status word, a reload value and the live count. Software reaches them over a plain synchronous bus with address, write strobe, write data, read strobe and registered read data. A channel counts one step per clock, up or down, while it is running. On arrival at its terminal value it raises a sticky hit flag. It then either reloads and runs on (periodic ticks) or stops itself (one-shot).

A level-held preload bit in the control word keeps the counter copying the reload register for as long as it is set, so a channel is normally armed in two writes: preload on, then run on with preload off. The hit flag is acknowledged by writing a one to it, so writing back a control word just read clears a pending event. Each channel drives its own interrupt line, the flag gated by an interrupt-enable bit. A start-both bit written to either channel sets the run bit of every channel on the same edge.

Top module: `dual_tick_timer`

## Requirements
- R1: After synchronous reset every register of both channels reads zero, `irq` is all zero and `bus_rdata` is zero.
- R2: Control word bits: 0 mode, 1 count-down, 2 generate select, 3 capture select, 4 auto-reload, 5 preload, 6 interrupt enable, 7 run, 8 hit flag, 9 pulse-width select, 10 start-both. Bits 0-7, 9 and 10 read back exactly as last written; bits 11 and up read as zero.
- R3: Word offsets for channel n are 0x00+16n (control), 0x04+16n (reload) and 0x08+16n (count). The reload register reads back as written. Writes to the count offset change nothing. Reads of offset 0x0C+16n, and any access with address bits [1:0] nonzero, return zero and write nothing.
- R4: While the preload bit is 1 the counter takes the reload register value on every clock and does not count.
- R5: With run 1 and preload 0 the counter steps by one each clock, downward when count-down is 1 and upward when it is 0. With run 0 and preload 0 it holds its value.
- R6: The terminal value is 0 counting down and all ones counting up. The hit flag is set on the same edge that the counter takes the terminal value.
- R7: With auto-reload 1, a running counter at its terminal value loads the reload register on the next clock, giving a period of reload+1 clocks.
- R8: With auto-reload 0, a channel reaching its terminal value clears its own run bit on that edge and then holds the terminal value.
- R9: Writing 1 to bit 8 clears the hit flag, and writing 0 to it leaves the flag unchanged. Writing back the control word just read therefore acknowledges the event. A hit on the same edge as a clearing write leaves the flag set.
- R10: `irq[n]` equals channel n's hit flag ANDed with its interrupt-enable bit. The flag is set even when the interrupt is disabled.
- R11: A control write with bit 10 set, to either channel, sets the run bit of both channels on that edge. The other bits of the unwritten channel are unchanged.
- R12: Activity in one channel leaves the other channel's registers and interrupt unchanged.
- R13: `bus_rdata` takes the selected register's value on the edge that samples `bus_re` high, and it holds its value on cycles with `bus_re` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data, valid the cycle after `bus_re` |
| irq | output | NUM_CH | Per-channel interrupt: hit flag AND interrupt enable |

## Verification
The bench builds the block with its defaults: two channels, 32-bit counters and a 5-bit address. With these values both channels and every register offset, including the unused and unaligned ones, can be reached. Small reload values make the down-count reload period and the one-shot stop visible within a few cycles. A reload value three below the top of the 32-bit range brings the all-ones terminal value of up-counting within reach without a long run. Start-both is exercised across the channel boundary.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

    localparam int CTRL_BITS = 11;

    // bit 10 down to bit 0 of the control/status word
    typedef struct packed {
        logic all_go;      // 10: start every channel
        logic pwm_sel;     // 9 : stored only
        logic hit_flag;    // 8 : sticky terminal-count flag, write 1 clears
        logic run;         // 7 : channel running
        logic irq_on;      // 6 : interrupt enable
        logic preload;     // 5 : counter follows reload register
        logic rearm;       // 4 : auto-reload
        logic cap_sel;     // 3 : stored only
        logic gen_sel;     // 2 : stored only
        logic count_down;  // 1 : direction
        logic mode_sel;    // 0 : stored only
    } ctrl_t;

    typedef enum logic [1:0] {
        REG_CTRL  = 2'd0,
        REG_LOAD  = 2'd1,
        REG_COUNT = 2'd2,
        REG_NONE  = 2'd3
    } reg_sel_e;

    function automatic ctrl_t ctrl_from_bus(input logic [CTRL_BITS-1:0] w);
        return ctrl_t'(w);
    endfunction

    function automatic logic [CTRL_BITS-1:0] ctrl_to_bus(input ctrl_t c);
        return CTRL_BITS'(c);
    endfunction

endpackage

// File: rtl/dtt_channel.sv
module dtt_channel
    import dtt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_we,
    input  logic             load_we,
    input  logic [CNT_W-1:0] wdata,
    input  logic             all_go_any,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] load_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq
);

    ctrl_t            wr_ctrl;
    ctrl_t            ctrl_n;
    logic [CNT_W-1:0] cnt_n;
    logic [CNT_W-1:0] term_val;
    logic             step_en;
    logic             hit;

    assign wr_ctrl  = ctrl_from_bus(wdata[CTRL_BITS-1:0]);
    assign step_en  = ctrl_q.run & ~ctrl_q.preload;
    assign term_val = ctrl_q.count_down ? '0 : '1;

    always_comb begin
        if (ctrl_q.preload) begin
            cnt_n = load_q;
        end else if (!ctrl_q.run) begin
            cnt_n = cnt_q;
        end else if (cnt_q == term_val) begin
            cnt_n = ctrl_q.rearm ? load_q : cnt_q;
        end else if (ctrl_q.count_down) begin
            cnt_n = cnt_q - 1'b1;
        end else begin
            cnt_n = cnt_q + 1'b1;
        end
    end

    assign hit = step_en & (cnt_n == term_val);

    always_comb begin
        ctrl_n = ctrl_q;
        if (ctrl_we) begin
            ctrl_n          = wr_ctrl;
            ctrl_n.hit_flag = ctrl_q.hit_flag & ~wr_ctrl.hit_flag;
        end else if (hit && !ctrl_q.rearm) begin
            ctrl_n.run = 1'b0;
        end
        if (hit) begin
            ctrl_n.hit_flag = 1'b1;
        end
        if (all_go_any) begin
            ctrl_n.run = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '0;
            cnt_q  <= '0;
        end else begin
            ctrl_q <= ctrl_n;
            cnt_q  <= cnt_n;
            if (load_we) begin
                load_q <= wdata;
            end
        end
    end

    assign irq = ctrl_q.hit_flag & ctrl_q.irq_on;

    a_r4_preload_follows: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.preload |=> cnt_q == $past(load_q));

    a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
        (step_en && ctrl_q.count_down && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);

    a_r5_step_up: assert property (@(posedge clk) disable iff (rst)
        (step_en && !ctrl_q.count_down && cnt_q != '1) |=> cnt_q == $past(cnt_q) + 1'b1);

    a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !ctrl_q.preload) |=> $stable(cnt_q));

    a_r6_flag_at_terminal: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_q.hit_flag) |-> (cnt_q == '0 || cnt_q == '1));

    a_r8_stop_sets_flag: assert property (@(posedge clk) disable iff (rst)
        ($fell(ctrl_q.run) && !$past(ctrl_we)) |-> ctrl_q.hit_flag);

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.hit_flag && !ctrl_we) |=> ctrl_q.hit_flag);

endmodule

// File: rtl/dtt_rdmux.sv
module dtt_rdmux
    import dtt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              aligned,
    input  logic [IDX_W-1:0]  idx,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] ctrl_w [NUM_CH],
    input  logic [DATA_W-1:0] load_w [NUM_CH],
    input  logic [DATA_W-1:0] cnt_w  [NUM_CH],
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (aligned && idx == IDX_W'(i)) begin
                case (reg_sel_e'(sel))
                    REG_CTRL:  pick = ctrl_w[i];
                    REG_LOAD:  pick = load_w[i];
                    REG_COUNT: pick = cnt_w[i];
                    default:   pick = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= pick;
        end
    end

    a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
    import dtt_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam int IDX_W = ADDR_W - 4;

    logic              aligned;
    logic [1:0]        reg_sel;
    logic [IDX_W-1:0]  ch_idx;
    logic [NUM_CH-1:0] ctrl_we;
    logic [NUM_CH-1:0] load_we;
    logic              all_go_any;
    logic [DATA_W-1:0] ctrl_w [NUM_CH];
    logic [DATA_W-1:0] load_w [NUM_CH];
    logic [DATA_W-1:0] cnt_w  [NUM_CH];

    assign aligned    = (bus_addr[1:0] == 2'b00);
    assign reg_sel    = bus_addr[3:2];
    assign ch_idx     = bus_addr[ADDR_W-1:4];
    assign all_go_any = (|ctrl_we) & bus_wdata[CTRL_BITS-1];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ctrl_t ch_ctrl;

        assign ctrl_we[g] = bus_we && aligned && ch_idx == IDX_W'(g)
                            && reg_sel_e'(reg_sel) == REG_CTRL;
        assign load_we[g] = bus_we && aligned && ch_idx == IDX_W'(g)
                            && reg_sel_e'(reg_sel) == REG_LOAD;

        dtt_channel #(
            .CNT_W (DATA_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .ctrl_we    (ctrl_we[g]),
            .load_we    (load_we[g]),
            .wdata      (bus_wdata),
            .all_go_any (all_go_any),
            .ctrl_q     (ch_ctrl),
            .load_q     (load_w[g]),
            .cnt_q      (cnt_w[g]),
            .irq        (irq[g])
        );

        assign ctrl_w[g] = {{(DATA_W-CTRL_BITS){1'b0}}, ctrl_to_bus(ch_ctrl)};

        a_r11_start_both: assert property (@(posedge clk) disable iff (rst)
            all_go_any |=> ch_ctrl.run);
    end

    dtt_rdmux #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_rdmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (bus_re),
        .aligned (aligned),
        .idx     (ch_idx),
        .sel     (reg_sel),
        .ctrl_w  (ctrl_w),
        .load_w  (load_w),
        .cnt_w   (cnt_w),
        .rdata   (bus_rdata)
    );

endmodule

// File: tb/test_dual_tick_timer.sv
`timescale 1ns/1ps
module test_dual_tick_timer;

    localparam int NUM_CH = 2;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 5;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_we = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NUM_CH-1:0] irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    typedef struct {
        logic [DATA_W-1:0] exp;
        string             tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    logic     rd_pend = 1'b0;

    always #2 clk = ~clk;

    dual_tick_timer #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) i_dual_tick_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one cycle after the strobe
    always @(posedge clk) rd_pend <= bus_re;

    always @(negedge clk) begin
        if (rd_pend) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard-empty", bus_rdata, '0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    // each task starts at a negedge and returns at the next negedge
    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        bus_re    = 1'b0;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
        sb_item_t it;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        bus_addr = a;
        bus_we   = 1'b0;
        bus_re   = 1'b1;
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            check(1'b0, "watchdog", '0, '1);
            report();
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(irq === '0, "R1 irq", DATA_W'(irq), '0);
        check(bus_rdata === '0, "R1 rdata", bus_rdata, '0);
        rd(5'h00, 32'h0, "R1 ch0 ctrl");
        rd(5'h04, 32'h0, "R1 ch0 load");
        rd(5'h08, 32'h0, "R1 ch0 count");
        rd(5'h10, 32'h0, "R1 ch1 ctrl");
        rd(5'h14, 32'h0, "R1 ch1 load");
        rd(5'h18, 32'h0, "R1 ch1 count");

        // R2 control readback
        wr(5'h00, 32'hFFFF_F20D);
        rd(5'h00, 32'h0000_020D, "R2 stored bits, upper zero");
        wr(5'h00, 32'h1);
        rd(5'h00, 32'h1, "R2 mode bit alone");
        wr(5'h00, 32'h0);

        // R3 map, ignored writes, unused/unaligned
        wr(5'h04, 32'hA5A5_0001);
        rd(5'h04, 32'hA5A5_0001, "R3 reload readback");
        wr(5'h08, 32'h0000_1234);
        rd(5'h08, 32'h0, "R3 count write ignored");
        rd(5'h0C, 32'h0, "R3 unused offset");
        wr(5'h05, 32'h0000_FFFF);
        rd(5'h04, 32'hA5A5_0001, "R3 unaligned write ignored");
        rd(5'h06, 32'h0, "R3 unaligned read");
        wr(5'h14, 32'h3C);
        rd(5'h14, 32'h3C, "R3 ch1 reload");
        rd(5'h04, 32'hA5A5_0001, "R12 ch0 reload kept");

        // R4 preload holds counter at reload value
        wr(5'h04, 32'h55);
        wr(5'h00, 32'hA2);
        idle(1);
        rd(5'h08, 32'h55, "R4 preload");
        rd(5'h08, 32'h55, "R4 preload no count");
        wr(5'h04, 32'h77);
        idle(1);
        rd(5'h08, 32'h77, "R4 follows reload");
        wr(5'h00, 32'h0);
        idle(2);
        rd(5'h08, 32'h77, "R5 idle holds");
        rd(5'h00, 32'h0, "R4 no flag while preloading");

        // R7 periodic down count, reload 3
        wr(5'h04, 32'h3);
        wr(5'h00, 32'h20);
        wr(5'h00, 32'h1D2);
        rd(5'h08, 32'h3, "R5 down start");
        rd(5'h08, 32'h2, "R5 down step");
        rd(5'h08, 32'h1, "R5 down step");
        rd(5'h08, 32'h0, "R6 terminal zero");
        rd(5'h08, 32'h3, "R7 reload");
        rd(5'h08, 32'h2, "R7 after reload");
        check(irq[0] === 1'b1, "R10 irq ch0 raised", DATA_W'(irq), 32'h1);
        rd(5'h18, 32'h0, "R12 ch1 count untouched");
        check(irq[1] === 1'b0, "R12 ch1 irq quiet", DATA_W'(irq), 32'h1);
        wr(5'h00, 32'h152);
        rd(5'h00, 32'h52, "R9 flag cleared on stop");
        check(irq[0] === 1'b0, "R10 irq ch0 dropped", DATA_W'(irq), 32'h0);
        rd(5'h08, 32'h3, "R7 stopped after reload");

        // R8 one-shot up to all ones, R9 write-back ack
        wr(5'h04, 32'hFFFF_FFFD);
        wr(5'h00, 32'h20);
        wr(5'h00, 32'hC0);
        idle(3);
        rd(5'h08, 32'hFFFF_FFFF, "R8 holds at all ones");
        rd(5'h00, 32'h140, "R8 run cleared, R6 flag set");
        check(irq[0] === 1'b1, "R10 irq one-shot", DATA_W'(irq), 32'h1);
        wr(5'h00, 32'h140);
        rd(5'h00, 32'h40, "R9 write-back acknowledges");
        check(irq[0] === 1'b0, "R9 irq after ack", DATA_W'(irq), 32'h0);
        rd(5'h08, 32'hFFFF_FFFF, "R8 still held");

        // R10 flag with interrupt disabled, ch1 one-shot down
        wr(5'h14, 32'h2);
        wr(5'h10, 32'h22);
        wr(5'h10, 32'h82);
        idle(4);
        rd(5'h10, 32'h102, "R10 flag set with irq off");
        check(irq[1] === 1'b0, "R10 irq gated", DATA_W'(irq), 32'h0);
        rd(5'h18, 32'h0, "R8 ch1 held at zero");
        wr(5'h10, 32'h002);
        rd(5'h10, 32'h102, "R9 write zero keeps flag");
        wr(5'h10, 32'h042);
        check(irq[1] === 1'b1, "R10 enable exposes flag", DATA_W'(irq), 32'h2);
        wr(5'h10, 32'h100);
        check(irq === '0, "R10 cleared", DATA_W'(irq), 32'h0);

        // R11 start-both from channel 0
        wr(5'h14, 32'd100);
        wr(5'h10, 32'h22);
        wr(5'h10, 32'h02);
        wr(5'h04, 32'd50);
        wr(5'h00, 32'h22);
        wr(5'h00, 32'h402);
        rd(5'h08, 32'd50, "R11 ch0 started");
        rd(5'h18, 32'd99, "R11 ch1 counting");
        rd(5'h00, 32'h482, "R11 ch0 run set");
        rd(5'h10, 32'h082, "R11 ch1 run set, rest kept");
        wr(5'h00, 32'h0);
        wr(5'h10, 32'h0);

        // R13 read data holds without strobe
        rd(5'h14, 32'd100, "R13 read");
        wr(5'h14, 32'd7);
        idle(1);
        check(bus_rdata === 32'd100, "R13 rdata held", bus_rdata, 32'd100);
        rd(5'h14, 32'd7, "R13 new value on strobe");

        idle(3);
        check(sb_q.size() == 0, "scoreboard drained", DATA_W'(sb_q.size()), '0);
        done = 1'b1;
        report();
    end

endmodule